// File: doc/BRIEF.md
# Twin-Clock Dual-Port RAM with Per-Port Read Latency

This block is a word-addressed memory shared by two masters. Each master has its own port and its own clock. Either port can read or write any word at any time, including the word the other port is using. The intended geometry is 16K words of 9 bits (`ADDR_W = 14`). The default parameters build a smaller array so that elaboration stays light.

Each port registers its controls on the rising edge of its own clock. A port takes part in an edge only when both of its selects are in their active state. A read/write line then picks whether the edge stores data or fetches it. A small address unit per port supplies the address for every access. It can load the external address, count upward, hold its value or return to zero, which allows burst transfers without driving a new address each cycle.

Read data can leave a port in one of two ways, picked per port by a static mode pin:
- **Flow-through:** the data appears one edge after the request.
- **Pipelined:** one more register stage is added, so the data appears two edges after the request.

An output-enable pin gates the result without waiting for a clock. Instead of a tri-state pad, each port presents a data bus and a drive flag that stands in for the pad being driven.

Top module: `twin_port_ram`

## Requirements
- R1: A port is selected at a rising edge of its clock only when `en0_n` is 0 and `en1` is 1 at that edge. At an edge where it is not selected the port stores nothing. In flow-through mode its `drive` is 0 from that edge until the next one.
- R2: At a selected edge with `wr_n` = 0, the port stores `din` into the word at its access address.
- R3: With `pipe` = 0, a selected edge with `wr_n` = 1 makes `drive` = 1 and `dout` = the word at the access address, from that edge until the next edge of the same clock.
- R4: With `pipe` = 1, the result of a read is presented one edge later than in R3. In each cycle, `drive` reflects the request registered two edges before. A read followed directly by a write still presents the read word in its slot, and `drive` then falls at the following edge.
- R5: While `oe_n` = 1, `drive` is 0 at once, with no clock edge needed. Whenever `drive` is 0, `dout` is all zeros.
- R6: The access address of an edge is chosen in this order of priority:
  - 0 when `clr_n` = 0;
  - otherwise `addr` when `load_n` = 0;
  - otherwise the previous access address plus one, wrapping from the top word to 0, when `step_n` = 0;
  - otherwise the previous access address.
- R7: The address unit of a port follows R6 on every edge, whether or not the port is selected.
- R8: A word written through either port is returned by a later read on the other port. After writes from both ports to one word, the later write is the one read.
- R9: When one port reads a word at the same edge at which the other port writes it, the read returns the old content. The next read returns the new content.
- R10: When both ports write the same word at the same edge of a shared clock, the word afterwards holds port A's data.
- R11: While `rst_x` = 1 at an edge, that port's access address becomes 0 and its `drive` becomes 0. Stored words are not changed by reset.
- R12: The latency mode of one port has no effect on the other port. Port A in flow-through mode and port B in pipelined mode each follow their own timing in the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en0_n_a | input | 1 | Port A select, active low |
| en1_a | input | 1 | Port A select, active high |
| wr_n_a | input | 1 | Port A: 0 = write, 1 = read |
| load_n_a | input | 1 | Port A: 0 = take external address |
| step_n_a | input | 1 | Port A: 0 = advance address unit |
| clr_n_a | input | 1 | Port A: 0 = address unit to zero |
| addr_a | input | ADDR_W | Port A external address |
| din_a | input | DATA_W | Port A write data |
| pipe_a | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| oe_n_a | input | 1 | Port A output enable, active low, unclocked |
| dout_a | output | DATA_W | Port A read data |
| drive_a | output | 1 | Port A output driven flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en0_n_b | input | 1 | Port B select, active low |
| en1_b | input | 1 | Port B select, active high |
| wr_n_b | input | 1 | Port B: 0 = write, 1 = read |
| load_n_b | input | 1 | Port B: 0 = take external address |
| step_n_b | input | 1 | Port B: 0 = advance address unit |
| clr_n_b | input | 1 | Port B: 0 = address unit to zero |
| addr_b | input | ADDR_W | Port B external address |
| din_b | input | DATA_W | Port B write data |
| pipe_b | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| oe_n_b | input | 1 | Port B output enable, active low, unclocked |
| dout_b | output | DATA_W | Port B read data |
| drive_b | output | 1 | Port B output driven flag |

## Verification
The hardest situations to reach from the ports are same-edge collisions on one word. One is a read on one port against a write on the other. The other is writes from both ports, which must leave port A's data whatever port last owned the word. The bench clocks both ports from one clock and lines both requests up at the same edge. It runs the double-write case twice: once after port B was the last writer and once after port A was. This exercises both states of the per-word ownership record. Pipelined read-then-write and the unclocked output enable are reached by changing inputs at exact cycles, and between edges for the output enable.

// File: rtl/tpr_pkg.sv
`timescale 1ns/1ps
package tpr_pkg;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

  // A port takes part in an edge only with both selects active.
  function automatic logic port_selected(input logic en0_n, input logic en1);
    return (!en0_n) && en1;
  endfunction

endpackage

// File: rtl/tpr_addr_cnt.sv
`timescale 1ns/1ps
module tpr_addr_cnt #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          step_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0] cur_q;

  // Access address of this edge: clear, then load, then advance, then hold.
  always_comb begin
    if (!clr_n) begin
      acc_addr = '0;
    end else if (!load_n) begin
      acc_addr = ext_addr;
    end else if (!step_n) begin
      acc_addr = cur_q + AW'(1);
    end else begin
      acc_addr = cur_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else begin
      cur_q <= acc_addr;
    end
  end

  assign cur_addr = cur_q;

endmodule

// File: rtl/tpr_store.sv
`timescale 1ns/1ps
module tpr_store #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  output logic [DW-1:0] q_a,
  input  logic          clk_b,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] q_b
);

  localparam int DEPTH = 1 << AW;

  // One data bank per writing port, plus one ownership bit per word and port.
  // Ownership bits equal: bank A holds the newest word; unequal: bank B does.
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic          own_a  [DEPTH];
  logic          own_b  [DEPTH];

  logic          clash;
  logic [DW-1:0] ra_a, ra_b, rb_a, rb_b;
  logic          ta_a, ta_b, tb_a, tb_b;

  // Both ports writing one word at a shared edge: port A must end as owner.
  assign clash = we_b && (addr_b == addr_a);

  always_ff @(posedge clk_a) begin
    if (we_a) begin
      bank_a[addr_a] <= din_a;
      own_a[addr_a]  <= clash ? ~own_a[addr_a] : own_b[addr_a];
    end
    ra_a <= bank_a[addr_a];
    ra_b <= bank_b[addr_a];
    ta_a <= own_a[addr_a];
    ta_b <= own_b[addr_a];
  end

  always_ff @(posedge clk_b) begin
    if (we_b) begin
      bank_b[addr_b] <= din_b;
      own_b[addr_b]  <= ~own_a[addr_b];
    end
    rb_a <= bank_a[addr_b];
    rb_b <= bank_b[addr_b];
    tb_a <= own_a[addr_b];
    tb_b <= own_b[addr_b];
  end

  assign q_a = (ta_a ^ ta_b) ? ra_b : ra_a;
  assign q_b = (tb_a ^ tb_b) ? rb_b : rb_a;

endmodule

// File: rtl/tpr_out_stage.sv
`timescale 1ns/1ps
module tpr_out_stage
  import tpr_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [DW-1:0] q,
  input  logic          pipe,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          drive
);

  lat_mode_e     mode;
  logic          s1_drive;
  logic          s2_drive;
  logic [DW-1:0] s2_data;
  logic          drv_sel;
  logic [DW-1:0] data_sel;

  assign mode = lat_mode_e'(pipe);

  // First stage: the drive flag follows the request; the data is the
  // memory's own read register.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_drive <= 1'b0;
    end else begin
      s1_drive <= rd_req;
    end
  end

  // Second stage runs in both modes, so a mode change needs no flush.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_drive <= 1'b0;
    end else begin
      s2_drive <= s1_drive;
    end
    s2_data <= q;
  end

  always_comb begin
    if (mode == LAT_PIPE) begin
      drv_sel  = s2_drive;
      data_sel = s2_data;
    end else begin
      drv_sel  = s1_drive;
      data_sel = q;
    end
  end

  assign drive = drv_sel && !oe_n;
  assign dout  = drive ? data_sel : '0;

endmodule

// File: rtl/twin_port_ram.sv
`timescale 1ns/1ps
module twin_port_ram
  import tpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              en0_n_a,
  input  logic              en1_a,
  input  logic              wr_n_a,
  input  logic              load_n_a,
  input  logic              step_n_a,
  input  logic              clr_n_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              pipe_a,
  input  logic              oe_n_a,
  output logic [DATA_W-1:0] dout_a,
  output logic              drive_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              en0_n_b,
  input  logic              en1_b,
  input  logic              wr_n_b,
  input  logic              load_n_b,
  input  logic              step_n_b,
  input  logic              clr_n_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic              pipe_b,
  input  logic              oe_n_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              drive_b
);

  logic              sel_a, sel_b;
  logic              we_a, we_b;
  logic              rd_a, rd_b;
  logic [ADDR_W-1:0] acc_addr_a, acc_addr_b;
  logic [ADDR_W-1:0] cur_addr_a, cur_addr_b;
  logic [DATA_W-1:0] q_a, q_b;

  assign sel_a = !rst_a && port_selected(en0_n_a, en1_a);
  assign sel_b = !rst_b && port_selected(en0_n_b, en1_b);
  assign we_a  = sel_a && !wr_n_a;
  assign we_b  = sel_b && !wr_n_b;
  assign rd_a  = sel_a && wr_n_a;
  assign rd_b  = sel_b && wr_n_b;

  tpr_addr_cnt #(.AW(ADDR_W)) u_cnt_a (
    .clk      (clk_a),
    .rst      (rst_a),
    .clr_n    (clr_n_a),
    .load_n   (load_n_a),
    .step_n   (step_n_a),
    .ext_addr (addr_a),
    .acc_addr (acc_addr_a),
    .cur_addr (cur_addr_a)
  );

  tpr_addr_cnt #(.AW(ADDR_W)) u_cnt_b (
    .clk      (clk_b),
    .rst      (rst_b),
    .clr_n    (clr_n_b),
    .load_n   (load_n_b),
    .step_n   (step_n_b),
    .ext_addr (addr_b),
    .acc_addr (acc_addr_b),
    .cur_addr (cur_addr_b)
  );

  tpr_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk_a  (clk_a),
    .we_a   (we_a),
    .addr_a (acc_addr_a),
    .din_a  (din_a),
    .q_a    (q_a),
    .clk_b  (clk_b),
    .we_b   (we_b),
    .addr_b (acc_addr_b),
    .din_b  (din_b),
    .q_b    (q_b)
  );

  tpr_out_stage #(.DW(DATA_W)) u_out_a (
    .clk    (clk_a),
    .rst    (rst_a),
    .rd_req (rd_a),
    .q      (q_a),
    .pipe   (pipe_a),
    .oe_n   (oe_n_a),
    .dout   (dout_a),
    .drive  (drive_a)
  );

  tpr_out_stage #(.DW(DATA_W)) u_out_b (
    .clk    (clk_b),
    .rst    (rst_b),
    .rd_req (rd_b),
    .q      (q_b),
    .pipe   (pipe_b),
    .oe_n   (oe_n_b),
    .dout   (dout_b),
    .drive  (drive_b)
  );

endmodule

// File: rtl/tpr_checker.sv
`timescale 1ns/1ps
module tpr_checker #(
  parameter int AW = 10
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          en0_n_a,
  input logic          en1_a,
  input logic          wr_n_a,
  input logic          load_n_a,
  input logic          clr_n_a,
  input logic [AW-1:0] addr_a,
  input logic          pipe_a,
  input logic          drive_a,
  input logic [AW-1:0] cur_addr_a,
  input logic          clk_b,
  input logic          rst_b,
  input logic          en0_n_b,
  input logic          en1_b,
  input logic          wr_n_b,
  input logic          load_n_b,
  input logic          step_n_b,
  input logic          clr_n_b,
  input logic          pipe_b,
  input logic          drive_b,
  input logic [AW-1:0] cur_addr_b
);

  logic no_rd_a, no_rd_b;
  assign no_rd_a = en0_n_a || !en1_a || !wr_n_a;
  assign no_rd_b = en0_n_b || !en1_b || !wr_n_b;

  AST_FLOW_IDLE_A: assert property (@(posedge clk_a) disable iff (rst_a)
    (no_rd_a && !pipe_a) ##1 !pipe_a |-> !drive_a); // R1

  AST_FLOW_IDLE_B: assert property (@(posedge clk_b) disable iff (rst_b)
    (no_rd_b && !pipe_b) ##1 !pipe_b |-> !drive_b); // R1

  AST_PIPE_IDLE_A: assert property (@(posedge clk_a) disable iff (rst_a)
    no_rd_a ##1 (no_rd_a && pipe_a) ##1 pipe_a |-> !drive_a); // R4

  AST_CNT_CLEAR_A: assert property (@(posedge clk_a) disable iff (rst_a)
    !clr_n_a |=> (cur_addr_a == '0)); // R6

  AST_CNT_LOAD_A: assert property (@(posedge clk_a) disable iff (rst_a)
    (clr_n_a && !load_n_a) |=> (cur_addr_a == $past(addr_a))); // R6

  AST_CNT_HOLD_B: assert property (@(posedge clk_b) disable iff (rst_b)
    (clr_n_b && load_n_b && step_n_b) |=> $stable(cur_addr_b)); // R7

endmodule

bind twin_port_ram tpr_checker #(.AW(ADDR_W)) u_chk (
  .clk_a      (clk_a),
  .rst_a      (rst_a),
  .en0_n_a    (en0_n_a),
  .en1_a      (en1_a),
  .wr_n_a     (wr_n_a),
  .load_n_a   (load_n_a),
  .clr_n_a    (clr_n_a),
  .addr_a     (addr_a),
  .pipe_a     (pipe_a),
  .drive_a    (drive_a),
  .cur_addr_a (cur_addr_a),
  .clk_b      (clk_b),
  .rst_b      (rst_b),
  .en0_n_b    (en0_n_b),
  .en1_b      (en1_b),
  .wr_n_b     (wr_n_b),
  .load_n_b   (load_n_b),
  .step_n_b   (step_n_b),
  .clr_n_b    (clr_n_b),
  .pipe_b     (pipe_b),
  .drive_b    (drive_b),
  .cur_addr_b (cur_addr_b)
);

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;

  localparam int AW   = 10;
  localparam int DW   = 9;
  localparam int MAXA = (1 << AW) - 1;

  logic          clk;
  logic          rst;
  logic          en0_n_a, en1_a, wr_n_a, load_n_a, step_n_a, clr_n_a, pipe_a, oe_n_a;
  logic [AW-1:0] addr_a;
  logic [DW-1:0] din_a, dout_a;
  logic          drive_a;
  logic          en0_n_b, en1_b, wr_n_b, load_n_b, step_n_b, clr_n_b, pipe_b, oe_n_b;
  logic [AW-1:0] addr_b;
  logic [DW-1:0] din_b, dout_b;
  logic          drive_b;

  int checks = 0;
  int errors = 0;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_a(clk), .rst_a(rst), .en0_n_a(en0_n_a), .en1_a(en1_a), .wr_n_a(wr_n_a),
    .load_n_a(load_n_a), .step_n_a(step_n_a), .clr_n_a(clr_n_a), .addr_a(addr_a),
    .din_a(din_a), .pipe_a(pipe_a), .oe_n_a(oe_n_a), .dout_a(dout_a), .drive_a(drive_a),
    .clk_b(clk), .rst_b(rst), .en0_n_b(en0_n_b), .en1_b(en1_b), .wr_n_b(wr_n_b),
    .load_n_b(load_n_b), .step_n_b(step_n_b), .clr_n_b(clr_n_b), .addr_b(addr_b),
    .din_b(din_b), .pipe_b(pipe_b), .oe_n_b(oe_n_b), .dout_b(dout_b), .drive_b(drive_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_d(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic a_idle();
    en0_n_a = 1'b1; en1_a = 1'b1; wr_n_a = 1'b1;
    load_n_a = 1'b1; step_n_a = 1'b1; clr_n_a = 1'b1;
  endtask

  task automatic b_idle();
    en0_n_b = 1'b1; en1_b = 1'b1; wr_n_b = 1'b1;
    load_n_b = 1'b1; step_n_b = 1'b1; clr_n_b = 1'b1;
  endtask

  task automatic a_req(input bit wr, input int ad, input int d);
    en0_n_a = 1'b0; en1_a = 1'b1; wr_n_a = !wr;
    load_n_a = 1'b0; step_n_a = 1'b1; clr_n_a = 1'b1;
    addr_a = AW'(ad); din_a = DW'(d);
  endtask

  task automatic b_req(input bit wr, input int ad, input int d);
    en0_n_b = 1'b0; en1_b = 1'b1; wr_n_b = !wr;
    load_n_b = 1'b0; step_n_b = 1'b1; clr_n_b = 1'b1;
    addr_b = AW'(ad); din_b = DW'(d);
  endtask

  task automatic a_write(input int ad, input int d);
    a_req(1'b1, ad, d); tick(); a_idle();
  endtask

  task automatic b_write(input int ad, input int d);
    b_req(1'b1, ad, d); tick(); b_idle();
  endtask

  task automatic a_read_chk(input string req, input int ad, input int exp);
    a_req(1'b0, ad, 0); tick();
    chk_b(req, "port A drive", drive_a, 1'b1);
    chk_d(req, "port A data", dout_a, DW'(exp));
    a_idle();
  endtask

  task automatic b_read_chk(input string req, input int ad, input int exp);
    b_req(1'b0, ad, 0); tick();
    chk_b(req, "port B drive", drive_b, 1'b1);
    chk_d(req, "port B data", dout_b, DW'(exp));
    b_idle();
  endtask

  task automatic t_reset();
    chk_b("R11", "drive A in reset", drive_a, 1'b0);
    chk_b("R11", "drive B in reset", drive_b, 1'b0);
    rst = 1'b0;
    a_write(0, 'h055);
    a_write(3, 'h033);
    rst = 1'b1; tick(); rst = 1'b0;
    en0_n_a = 1'b0; en1_a = 1'b1; wr_n_a = 1'b1;
    tick();
    chk_d("R11", "address unit zero after reset, word kept", dout_a, 9'h055);
    a_idle();
  endtask

  task automatic t_flow();
    a_write(5, 'h1A5);
    a_write(6, 'h05A);
    a_read_chk("R3", 5, 'h1A5);
    tick();
    chk_b("R3", "drive falls after idle edge", drive_a, 1'b0);
    chk_d("R5", "dout zero when not driven", dout_a, 9'h000);
    a_read_chk("R2", 6, 'h05A);
  endtask

  task automatic t_cross();
    b_read_chk("R8", 6, 'h05A);
    b_write(7, 'h133);
    a_read_chk("R8", 7, 'h133);
    a_write(7, 'h0C3);
    b_read_chk("R8", 7, 'h0C3);
    b_write(7, 'h111);
    a_read_chk("R8", 7, 'h111);
  endtask

  task automatic t_select();
    a_req(1'b1, 5, 'h0FF); en1_a = 1'b0; tick();
    en0_n_a = 1'b1; en1_a = 1'b1; tick();
    a_idle();
    a_read_chk("R1", 5, 'h1A5);
    a_req(1'b0, 5, 0); en1_a = 1'b0; tick();
    chk_b("R1", "deselected read not driven", drive_a, 1'b0);
    chk_d("R1", "deselected read data zero", dout_a, 9'h000);
    a_idle();
  endtask

  task automatic t_pipe();
    pipe_b = 1'b1; tick();
    b_req(1'b0, 5, 0); a_req(1'b0, 6, 0); tick();
    chk_b("R12", "flow port A drives while B pipelined", drive_a, 1'b1);
    chk_d("R12", "flow port A data", dout_a, 9'h05A);
    chk_b("R4", "pipelined B not yet driven", drive_b, 1'b0);
    a_idle(); b_idle(); tick();
    chk_b("R4", "pipelined B drive", drive_b, 1'b1);
    chk_d("R4", "pipelined B data", dout_b, 9'h1A5);
    chk_b("R12", "flow port A off", drive_a, 1'b0);
    tick();
    chk_b("R4", "pipelined B off", drive_b, 1'b0);
  endtask

  task automatic t_pipe_rw();
    b_req(1'b0, 6, 0); tick();
    b_req(1'b1, 8, 'h0AA); tick();
    chk_b("R4", "read slot kept before write", drive_b, 1'b1);
    chk_d("R4", "read slot data", dout_b, 9'h05A);
    b_idle(); tick();
    chk_b("R4", "off after write", drive_b, 1'b0);
    pipe_b = 1'b0;
    a_read_chk("R4", 8, 'h0AA);
  endtask

  task automatic t_oe();
    a_req(1'b0, 5, 0); tick(); a_idle();
    #2 oe_n_a = 1'b1;
    #1;
    chk_b("R5", "oe high drops drive at once", drive_a, 1'b0);
    chk_d("R5", "oe high zeroes dout", dout_a, 9'h000);
    oe_n_a = 1'b0;
    #1;
    chk_b("R5", "oe low restores drive", drive_a, 1'b1);
    chk_d("R5", "oe low restores data", dout_a, 9'h1A5);
    tick();
  endtask

  task automatic t_counter();
    a_req(1'b1, 20, 'h101); tick();
    load_n_a = 1'b1; step_n_a = 1'b0; din_a = 9'h102; tick();
    din_a = 9'h103; tick();
    a_req(1'b0, 21, 0); tick();
    chk_d("R6", "load address 21", dout_a, 9'h102);
    load_n_a = 1'b1; step_n_a = 1'b1; tick();
    chk_d("R6", "hold keeps 21", dout_a, 9'h102);
    step_n_a = 1'b0; tick();
    chk_d("R6", "advance to 22", dout_a, 9'h103);
    step_n_a = 1'b1; clr_n_a = 1'b0; tick();
    chk_d("R6", "clear to 0", dout_a, 9'h055);
    load_n_a = 1'b0; addr_a = AW'(22); tick();
    chk_d("R6", "clear beats load", dout_a, 9'h055);
    a_idle();
  endtask

  task automatic t_cnt_desel();
    a_req(1'b1, 20, 'h000); en0_n_a = 1'b1; tick();
    chk_b("R1", "deselected edge not driven", drive_a, 1'b0);
    load_n_a = 1'b1; step_n_a = 1'b0; tick();
    en0_n_a = 1'b0; wr_n_a = 1'b1; step_n_a = 1'b1; tick();
    chk_d("R7", "unit loaded and advanced while deselected", dout_a, 9'h102);
    a_idle();
    a_read_chk("R1", 20, 'h101);
  endtask

  task automatic t_wrap();
    a_write(MAXA, 'h1E1);
    a_req(1'b0, MAXA, 0); tick();
    chk_d("R6", "top word", dout_a, 9'h1E1);
    load_n_a = 1'b1; step_n_a = 1'b0; tick();
    chk_d("R6", "advance wraps to 0", dout_a, 9'h055);
    a_idle();
  endtask

  task automatic t_collide_rd();
    a_write(40, 'h044);
    a_req(1'b1, 40, 'h0EE); b_req(1'b0, 40, 0); tick();
    chk_d("R9", "same-edge read gets old word", dout_b, 9'h044);
    a_idle(); b_idle();
    b_read_chk("R9", 40, 'h0EE);
  endtask

  task automatic t_collide_wr();
    b_write(50, 'h001);
    a_req(1'b1, 50, 'h1AA); b_req(1'b1, 50, 'h0BB); tick();
    a_idle(); b_idle();
    b_read_chk("R10", 50, 'h1AA);
    a_read_chk("R10", 50, 'h1AA);
    a_req(1'b1, 50, 'h02D); b_req(1'b1, 50, 'h1C0); tick();
    a_idle(); b_idle();
    b_read_chk("R10", 50, 'h02D);
    b_write(50, 'h077);
    a_read_chk("R8", 50, 'h077);
  endtask

  initial begin
    rst = 1'b1;
    a_idle(); b_idle();
    addr_a = '0; din_a = '0; addr_b = '0; din_b = '0;
    pipe_a = 1'b0; pipe_b = 1'b0; oe_n_a = 1'b0; oe_n_b = 1'b0;
    repeat (3) tick();
    t_reset();
    t_flow();
    t_cross();
    t_select();
    t_pipe();
    t_pipe_rw();
    t_oe();
    t_counter();
    t_cnt_desel();
    t_wrap();
    t_collide_rd();
    t_collide_wr();
    repeat (2) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule